// File: doc/BRIEF.md
# System Register Access Gate

This block rules on every access an instruction makes to a small group of privileged control registers. There are two families of extension registers. The system-control extension has a copy for privilege levels 1, 2 and 3. The translation-control extension has a copy for levels 1 and 2. Each family also has a level-1-and-2 alias encoding, which a level-2 host uses to reach the level-1 copy. The block receives the five-field register encoding, the direction of the access, the current privilege level, the features the implementation has, and the enable and trap bits from the secure, hypervisor and extended hypervisor configuration. From these it gives one verdict: allow, undefined, trap to level 2, or trap to level 3.

When the encoding belongs to none of the seven registers, the block raises `not_mine` so that another decoder can claim the access. When the encoding is recognised, it also gives a register index. For an alias, that index is the index of the level-1 register the alias stands for. All outputs are registered and appear one clock after the inputs are sampled. The register contents and the raising of the exception belong to other blocks.

Top module: `sre_access_gate`

## Requirements
- R1: Reset drives every output to 0. Otherwise, each output reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R2: Encodings (op0,op1,CRn,CRm,op2) are decoded to an index as follows: (3,0,1,0,3)=0 sysctl L1, (3,0,2,0,3)=1 xlat L1, (3,4,1,0,3)=2 sysctl L2, (3,4,2,0,3)=3 xlat L2, (3,5,1,0,3) sysctl alias, (3,5,2,0,3) xlat alias, (3,6,1,0,3)=4 sysctl L3. Any other encoding sets `not_mine`=1, all verdict flags to 0 and `reg_idx` to 0.
- R3: For a recognised encoding, exactly one verdict flag is 1 and `not_mine` is 0. `reg_idx` is the register's own index, and an alias reports the index of its level-1 register (0 or 1).
- R4: If the feature of the register's family is absent (`has_sysctl_ext` or `has_xlat_ext`), the verdict is undefined, whatever the other inputs are.
- R5: An access from level 0 is undefined. A level-2 register or an alias accessed from level 1 is undefined. The level-3 register accessed below level 3 is undefined.
- R6: For a level-1 register accessed at level 1 with `pl2_active`=1, the verdict is trap to level 2 when either of these holds: the family's fine-grained trap bit is set, or the coarse bit is set (`trap_vm_rd` for a read, `trap_vm_wr` for a write).
- R7: If R6 does not apply, and `pl2_active`=1, the verdict is trap to level 2 when either of these holds: the extended hypervisor register is not effective, or its family enable is clear. The register is effective when `has_hyp_ext`=1, `pl2_active`=1, and either `has_pl3`=0 or `sec_hyp_ext_en`=1.
- R8: If R6 and R7 do not apply, the verdict is trap to level 3 when `has_pl3`=1 and the family's secure enable is clear. Otherwise the access is allowed.
- R9: At level 2, a level-1 or level-2 register traps to level 3 when `has_pl3`=1 and the family's secure enable is clear, and is allowed otherwise. At level 3, both are allowed.
- R10: An alias accessed at level 2 is undefined when `host_mode`=0. When `host_mode`=1, the R9 level-3 check applies.
- R11: An alias accessed at level 3 is allowed when both `pl2_active` and `host_mode` are 1, and is undefined otherwise.
- R12: The level-3 system-control register accessed at level 3 is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_is_read | input | 1 | 1 = read, 0 = write |
| cur_pl | input | 2 | Current privilege level 0..3 |
| has_sysctl_ext | input | 1 | System-control extension implemented |
| has_xlat_ext | input | 1 | Translation-control extension implemented |
| has_hyp_ext | input | 1 | Extended hypervisor register implemented |
| has_pl3 | input | 1 | Level 3 implemented |
| pl2_active | input | 1 | Level 2 enabled in the current state |
| host_mode | input | 1 | Hypervisor host-mode bit |
| trap_vm_rd | input | 1 | Coarse trap of reads of memory-control registers |
| trap_vm_wr | input | 1 | Coarse trap of writes of memory-control registers |
| fg_trap_sysctl | input | 1 | Fine-grained trap, system-control family |
| fg_trap_xlat | input | 1 | Fine-grained trap, translation-control family |
| sec_sysctl_en | input | 1 | Secure configuration enable, system-control family |
| sec_xlat_en | input | 1 | Secure configuration enable, translation-control family |
| sec_hyp_ext_en | input | 1 | Secure configuration enable of the extended hypervisor register |
| hx_sysctl_en | input | 1 | Extended hypervisor enable, system-control family |
| hx_xlat_en | input | 1 | Extended hypervisor enable, translation-control family |
| not_mine | output | 1 | Encoding not recognised |
| v_allow | output | 1 | Verdict: allow |
| v_undef | output | 1 | Verdict: undefined |
| v_trap_pl2 | output | 1 | Verdict: trap to level 2 |
| v_trap_pl3 | output | 1 | Verdict: trap to level 3 |
| reg_idx | output | 3 | Resolved register index |

## Verification
The assertions assume that every input holds a defined 0 or 1 at each rising edge. They make no assumption that the configuration is self-consistent. For example, `host_mode` or the trap bits may be set while `pl2_active` is clear, and the verdict must still follow the fixed priority. The stimulus changes inputs only just after an edge. It sweeps every combination of the eleven feature and enable bits against all seven encodings, a near-miss encoding, all four levels and both directions. The trap bits are mixed in from a hash of the loop indices, so each of them meets both values in every other combination's neighbourhood.

// File: rtl/sre_pkg.sv
package sre_pkg;

    localparam int NUM_ENC     = 7;
    localparam int NUM_TARGETS = 5;
    localparam int IDX_W       = $clog2(NUM_TARGETS);

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } enc_t;

    typedef enum logic [1:0] {
        K_L1    = 2'd0,
        K_L2    = 2'd1,
        K_ALIAS = 2'd2,
        K_L3    = 2'd3
    } kind_t;

    typedef struct packed {
        logic allow;
        logic undef;
        logic trap2;
        logic trap3;
    } verdict_t;

    typedef struct packed {
        logic             not_mine;
        verdict_t         v;
        logic [IDX_W-1:0] idx;
    } gate_out_t;

    // family: 0 = system control, 1 = translation control
    function automatic logic entry_fam(int i);
        return (i % 2) == 1;
    endfunction

    function automatic kind_t entry_kind(int i);
        case (i)
            0, 1:    return K_L1;
            2, 3:    return K_L2;
            4, 5:    return K_ALIAS;
            default: return K_L3;
        endcase
    endfunction

    function automatic enc_t entry_enc(int i);
        enc_t e;
        e.op0 = 2'd3;
        e.crm = 4'd0;
        e.op2 = 3'd3;
        e.crn = entry_fam(i) ? 4'd2 : 4'd1;
        case (entry_kind(i))
            K_L1:    e.op1 = 3'd0;
            K_L2:    e.op1 = 3'd4;
            K_ALIAS: e.op1 = 3'd5;
            default: e.op1 = 3'd6;
        endcase
        return e;
    endfunction

    // aliases resolve to the level-1 register of their family
    function automatic logic [IDX_W-1:0] entry_idx(int i);
        case (i)
            4:       return IDX_W'(0);
            5:       return IDX_W'(1);
            6:       return IDX_W'(4);
            default: return IDX_W'(i);
        endcase
    endfunction

endpackage

// File: rtl/sre_decode.sv
module sre_decode
    import sre_pkg::*;
(
    input  enc_t             enc,
    output logic             hit,
    output kind_t            kind,
    output logic             fam,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_ENC-1:0] match;

    for (genvar g = 0; g < NUM_ENC; g++) begin : g_match
        assign match[g] = (enc == entry_enc(g));
    end

    always_comb begin
        hit  = |match;
        kind = K_L1;
        fam  = 1'b0;
        idx  = '0;
        for (int i = 0; i < NUM_ENC; i++) begin
            if (match[i]) begin
                kind = entry_kind(i);
                fam  = entry_fam(i);
                idx  = entry_idx(i);
            end
        end
    end
endmodule

// File: rtl/sre_policy.sv
module sre_policy
    import sre_pkg::*;
(
    input  logic       hit,
    input  kind_t      kind,
    input  logic       fam,
    input  logic       is_read,
    input  logic [1:0] pl,
    input  logic       has_sysctl_ext,
    input  logic       has_xlat_ext,
    input  logic       has_hyp_ext,
    input  logic       has_pl3,
    input  logic       pl2_active,
    input  logic       host_mode,
    input  logic       trap_vm_rd,
    input  logic       trap_vm_wr,
    input  logic       fg_trap_sysctl,
    input  logic       fg_trap_xlat,
    input  logic       sec_sysctl_en,
    input  logic       sec_xlat_en,
    input  logic       sec_hyp_ext_en,
    input  logic       hx_sysctl_en,
    input  logic       hx_xlat_en,
    output verdict_t   verdict
);
    logic feat_ok, sec_en, hx_en, fg_hit, coarse_hit;
    logic hx_effective, pl3_block;

    always_comb begin
        feat_ok      = fam ? has_xlat_ext   : has_sysctl_ext;
        sec_en       = fam ? sec_xlat_en    : sec_sysctl_en;
        hx_en        = fam ? hx_xlat_en     : hx_sysctl_en;
        fg_hit       = fam ? fg_trap_xlat   : fg_trap_sysctl;
        coarse_hit   = is_read ? trap_vm_rd : trap_vm_wr;
        hx_effective = has_hyp_ext && pl2_active && (!has_pl3 || sec_hyp_ext_en);
        pl3_block    = has_pl3 && !sec_en;
    end

    always_comb begin
        verdict = '0;
        if (hit) begin
            if (!feat_ok || pl == 2'd0) begin
                verdict.undef = 1'b1;
            end else begin
                unique case (kind)
                    K_L1: begin
                        if (pl == 2'd1) begin
                            if (pl2_active && (fg_hit || coarse_hit))
                                verdict.trap2 = 1'b1;
                            else if (pl2_active && (!hx_effective || !hx_en))
                                verdict.trap2 = 1'b1;
                            else if (pl3_block)
                                verdict.trap3 = 1'b1;
                            else
                                verdict.allow = 1'b1;
                        end else if (pl == 2'd2 && pl3_block) begin
                            verdict.trap3 = 1'b1;
                        end else begin
                            verdict.allow = 1'b1;
                        end
                    end
                    K_L2: begin
                        if (pl == 2'd1)
                            verdict.undef = 1'b1;
                        else if (pl == 2'd2 && pl3_block)
                            verdict.trap3 = 1'b1;
                        else
                            verdict.allow = 1'b1;
                    end
                    K_ALIAS: begin
                        if (pl == 2'd1)
                            verdict.undef = 1'b1;
                        else if (pl == 2'd2) begin
                            if (!host_mode)
                                verdict.undef = 1'b1;
                            else if (pl3_block)
                                verdict.trap3 = 1'b1;
                            else
                                verdict.allow = 1'b1;
                        end else if (pl2_active && host_mode)
                            verdict.allow = 1'b1;
                        else
                            verdict.undef = 1'b1;
                    end
                    default: begin
                        if (pl == 2'd3)
                            verdict.allow = 1'b1;
                        else
                            verdict.undef = 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sre_access_gate.sv
module sre_access_gate
    import sre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       acc_op0,
    input  logic [2:0]       acc_op1,
    input  logic [3:0]       acc_crn,
    input  logic [3:0]       acc_crm,
    input  logic [2:0]       acc_op2,
    input  logic             acc_is_read,
    input  logic [1:0]       cur_pl,
    input  logic             has_sysctl_ext,
    input  logic             has_xlat_ext,
    input  logic             has_hyp_ext,
    input  logic             has_pl3,
    input  logic             pl2_active,
    input  logic             host_mode,
    input  logic             trap_vm_rd,
    input  logic             trap_vm_wr,
    input  logic             fg_trap_sysctl,
    input  logic             fg_trap_xlat,
    input  logic             sec_sysctl_en,
    input  logic             sec_xlat_en,
    input  logic             sec_hyp_ext_en,
    input  logic             hx_sysctl_en,
    input  logic             hx_xlat_en,
    output logic             not_mine,
    output logic             v_allow,
    output logic             v_undef,
    output logic             v_trap_pl2,
    output logic             v_trap_pl3,
    output logic [IDX_W-1:0] reg_idx
);
    enc_t             enc;
    logic             dec_hit;
    kind_t            dec_kind;
    logic             dec_fam;
    logic [IDX_W-1:0] dec_idx;
    verdict_t         pol_verdict;
    gate_out_t        out_d, out_q;

    assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

    sre_decode u_decode (
        .enc  (enc),
        .hit  (dec_hit),
        .kind (dec_kind),
        .fam  (dec_fam),
        .idx  (dec_idx)
    );

    sre_policy u_policy (
        .hit            (dec_hit),
        .kind           (dec_kind),
        .fam            (dec_fam),
        .is_read        (acc_is_read),
        .pl             (cur_pl),
        .has_sysctl_ext (has_sysctl_ext),
        .has_xlat_ext   (has_xlat_ext),
        .has_hyp_ext    (has_hyp_ext),
        .has_pl3        (has_pl3),
        .pl2_active     (pl2_active),
        .host_mode      (host_mode),
        .trap_vm_rd     (trap_vm_rd),
        .trap_vm_wr     (trap_vm_wr),
        .fg_trap_sysctl (fg_trap_sysctl),
        .fg_trap_xlat   (fg_trap_xlat),
        .sec_sysctl_en  (sec_sysctl_en),
        .sec_xlat_en    (sec_xlat_en),
        .sec_hyp_ext_en (sec_hyp_ext_en),
        .hx_sysctl_en   (hx_sysctl_en),
        .hx_xlat_en     (hx_xlat_en),
        .verdict        (pol_verdict)
    );

    always_comb begin
        out_d          = '0;
        out_d.not_mine = !dec_hit;
        out_d.v        = pol_verdict;
        out_d.idx      = dec_hit ? dec_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign not_mine   = out_q.not_mine;
    assign v_allow    = out_q.v.allow;
    assign v_undef    = out_q.v.undef;
    assign v_trap_pl2 = out_q.v.trap2;
    assign v_trap_pl3 = out_q.v.trap3;
    assign reg_idx    = out_q.idx;
endmodule

// File: rtl/sre_access_gate_chk.sv
module sre_access_gate_chk
    import sre_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       acc_op0,
    input logic [2:0]       acc_op1,
    input logic [3:0]       acc_crn,
    input logic [3:0]       acc_crm,
    input logic [2:0]       acc_op2,
    input logic [1:0]       cur_pl,
    input logic             has_sysctl_ext,
    input logic             has_xlat_ext,
    input logic             pl2_active,
    input logic             host_mode,
    input logic             not_mine,
    input logic             v_allow,
    input logic             v_undef,
    input logic             v_trap_pl2,
    input logic             v_trap_pl3,
    input logic [IDX_W-1:0] reg_idx
);
    logic primed;
    logic known_now;
    enc_t seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    always_comb begin
        seen      = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};
        known_now = 1'b0;
        for (int i = 0; i < NUM_ENC; i++)
            if (seen == entry_enc(i)) known_now = 1'b1;
    end

    a_r2_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(known_now) |->
            not_mine && !v_allow && !v_undef && !v_trap_pl2 && !v_trap_pl3 && reg_idx == '0);

    a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !not_mine |-> $onehot({v_allow, v_undef, v_trap_pl2, v_trap_pl3}));

    a_r4_feature_absent: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !not_mine &&
        (($past(acc_crn) == 4'd1 && !$past(has_sysctl_ext)) ||
         ($past(acc_crn) == 4'd2 && !$past(has_xlat_ext))) |-> v_undef);

    a_r5_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !not_mine && $past(cur_pl) == 2'd0 |-> v_undef);

    a_r11_alias_top: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !not_mine && $past(acc_op1) == 3'd5 && $past(cur_pl) == 2'd3 &&
        !($past(pl2_active) && $past(host_mode)) |-> v_undef);

    a_r12_top_reg: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !not_mine && $past(acc_op1) == 3'd6 && $past(cur_pl) == 2'd3 &&
        $past(has_sysctl_ext) |-> v_allow);
endmodule

bind sre_access_gate sre_access_gate_chk u_chk (.*);

// File: tb/test_sre_access_gate.sv
module test_sre_access_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] acc_op0 = '0;
    logic [2:0] acc_op1 = '0;
    logic [3:0] acc_crn = '0;
    logic [3:0] acc_crm = '0;
    logic [2:0] acc_op2 = '0;
    logic acc_is_read = 1'b0;
    logic [1:0] cur_pl = '0;
    logic has_sysctl_ext = 0, has_xlat_ext = 0, has_hyp_ext = 0, has_pl3 = 0;
    logic pl2_active = 0, host_mode = 0, trap_vm_rd = 0, trap_vm_wr = 0;
    logic fg_trap_sysctl = 0, fg_trap_xlat = 0;
    logic sec_sysctl_en = 0, sec_xlat_en = 0, sec_hyp_ext_en = 0;
    logic hx_sysctl_en = 0, hx_xlat_en = 0;
    logic not_mine, v_allow, v_undef, v_trap_pl2, v_trap_pl3;
    logic [2:0] reg_idx;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sre_access_gate i_sre_access_gate (.*);

    // encodings 0..6 are the registers, 7 is a near miss (op2 = 2)
    function automatic void set_enc(int e);
        acc_op0 = 2'd3;
        acc_crm = 4'd0;
        acc_op2 = (e == 7) ? 3'd2 : 3'd3;
        acc_crn = (e % 2 == 1) ? 4'd2 : 4'd1;
        case (e)
            0, 1, 7: acc_op1 = 3'd0;
            2, 3:    acc_op1 = 3'd4;
            4, 5:    acc_op1 = 3'd5;
            default: acc_op1 = 3'd6;
        endcase
    endfunction

    // expected result from the requirements; v = {allow, undef, trap2, trap3}
    function automatic void model(input int e, output logic nm, output logic [3:0] v,
                                  output logic [2:0] idx, output string tag);
        logic xl, feat, sec, hx, lvl3_gate, hx_good;
        nm = 1'b0; v = 4'b0000; idx = 3'd0; tag = "R2";
        if (e == 7) begin
            nm = 1'b1;
            return;
        end
        xl   = (e % 2 == 1);
        feat = xl ? has_xlat_ext : has_sysctl_ext;
        sec  = xl ? sec_xlat_en : sec_sysctl_en;
        hx   = xl ? hx_xlat_en : hx_sysctl_en;
        lvl3_gate = has_pl3 && !sec;
        hx_good = has_hyp_ext && pl2_active && (!has_pl3 || sec_hyp_ext_en) && hx;
        idx = (e == 6) ? 3'd4 : (e >= 4) ? 3'(e - 4) : 3'(e);
        if (!feat) begin
            v = 4'b0100; tag = "R3,R4"; return;
        end
        if (cur_pl == 2'd0) begin
            v = 4'b0100; tag = "R3,R5"; return;
        end
        if (e == 6) begin
            if (cur_pl == 2'd3) begin v = 4'b1000; tag = "R3,R12"; end
            else begin v = 4'b0100; tag = "R3,R5"; end
            return;
        end
        if (cur_pl == 2'd1) begin
            if (e >= 2) begin v = 4'b0100; tag = "R3,R5"; return; end
            if (pl2_active && ((xl ? fg_trap_xlat : fg_trap_sysctl) ||
                               (acc_is_read ? trap_vm_rd : trap_vm_wr))) begin
                v = 4'b0010; tag = "R3,R6"; return;
            end
            if (pl2_active && !hx_good) begin v = 4'b0010; tag = "R3,R7"; return; end
            v = lvl3_gate ? 4'b0001 : 4'b1000; tag = "R3,R8";
            return;
        end
        if (e >= 4) begin
            if (cur_pl == 2'd2) begin
                tag = "R3,R10";
                if (!host_mode) v = 4'b0100;
                else v = lvl3_gate ? 4'b0001 : 4'b1000;
            end else begin
                tag = "R3,R11";
                v = (pl2_active && host_mode) ? 4'b1000 : 4'b0100;
            end
            return;
        end
        tag = "R3,R9";
        v = (cur_pl == 2'd2 && lvl3_gate) ? 4'b0001 : 4'b1000;
    endfunction

    task automatic check(input string tag, input logic nm, input logic [3:0] v, input logic [2:0] idx);
        logic [7:0] act, exp;
        act = {not_mine, v_allow, v_undef, v_trap_pl2, v_trap_pl3, reg_idx};
        exp = {nm, v, idx};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL %s: got nm/v/idx=%b expected %b (pl=%0d op1=%0d crn=%0d rd=%0d)",
                         tag, act, exp, cur_pl, acc_op1, acc_crn, acc_is_read);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic nm;
        logic [3:0] v;
        logic [2:0] idx;
        string tag;

        // R1: outputs held at 0 under reset even with a recognised access
        set_enc(6);
        cur_pl = 2'd3;
        has_sysctl_ext = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 4'b0000, 3'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1,R12", 1'b0, 4'b1000, 3'd4);

        // R1: mid-cycle change is not visible before the next edge
        cur_pl = 2'd0;
        #2;
        check("R1 hold", 1'b0, 4'b1000, 3'd4);
        @(posedge clk);
        #1;
        check("R1,R5", 1'b0, 4'b0100, 3'd4);

        for (int cfg = 0; cfg < 2048; cfg++) begin
            has_sysctl_ext = cfg[0];
            has_xlat_ext   = cfg[1];
            has_hyp_ext    = cfg[2];
            has_pl3        = cfg[3];
            pl2_active     = cfg[4];
            host_mode      = cfg[5];
            sec_sysctl_en  = cfg[6];
            sec_xlat_en    = cfg[7];
            sec_hyp_ext_en = cfg[8];
            hx_sysctl_en   = cfg[9];
            hx_xlat_en     = cfg[10];
            for (int e = 0; e < 8; e++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int rw = 0; rw < 2; rw++) begin
                        int k;
                        k = cfg * 13 + e * 5 + p * 3 + rw;
                        fg_trap_sysctl = k[2];
                        fg_trap_xlat   = k[3];
                        trap_vm_rd     = k[4];
                        trap_vm_wr     = k[5];
                        acc_is_read    = rw[0];
                        cur_pl         = 2'(p);
                        set_enc(e);
                        model(e, nm, v, idx, tag);
                        @(posedge clk);
                        #1;
                        check(tag, nm, v, idx);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule